// File: doc/BRIEF.md
# Frame-Triggered Program Sequencer

This block drives instruction fetch for a processing core that runs its whole program once per audio sample frame. When a frame tick is accepted, the fetch address is loaded with the program start address. An instruction-valid strobe is raised, and the address then advances by one every cycle. The program memory returns the instruction word for the current fetch address in the same cycle.

When the fetched word carries the jump-to-start opcode, the sequencer parks at the start address and drops the strobe. It then waits for the next frame.

Three control inputs gate execution:
- A core enable. Without it, nothing else has any effect.
- A run request. Clearing it halts the program at once, so that program and coefficient memories can be reloaded safely.
- A 4-bit frame-rate select. Its all-ones code means "no rate", and frames are then ignored.

If a frame arrives before the program has finished, the sequencer restarts from the start address and sets a sticky overrun flag.

Top module: `frame_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `fetch_addr` = START_ADDR, `instr_valid` = 0 and `overrun` = 0.
- R2: A frame is accepted when `frame_tick`, `core_en` and `run_req` are all high and `rate_sel` is not 4'b1111. While idle, an accepted frame gives `fetch_addr` = START_ADDR and `instr_valid` = 1 in the next cycle.
- R3: Each cycle, while `instr_valid` is high and no jump, halt or new frame applies, `fetch_addr` increases by exactly one, modulo 2^ADDR_W.
- R4: The opcode field is the top OPC_W bits of `instr_word`. When this field equals JUMP_OPC (default 5'h1F) while `instr_valid` is high, the next cycle has `instr_valid` = 0 and `fetch_addr` = START_ADDR. The sequencer stays there until the next accepted frame.
- R5: While waiting for a frame, `instr_valid` is 0 and `fetch_addr` holds START_ADDR.
- R6: When `rate_sel` = 4'b1111, `frame_tick` has no effect: an idle sequencer stays idle.
- R7: While `core_en` is low, `run_req` and `frame_tick` have no effect, and the sequencer stays idle at START_ADDR.
- R8: If `run_req` or `core_en` is low at a clock edge, the next cycle shows `instr_valid` = 0 and `fetch_addr` = START_ADDR, even in mid-program.
- R9: A frame accepted while `instr_valid` is high sets `overrun` and restarts at START_ADDR with `instr_valid` = 1 in the next cycle. This also applies in the cycle where the jump opcode is fetched, because the frame takes priority over the jump.
- R10: Once set, `overrun` stays high until `rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_en | input | 1 | Core enable; qualifies every other control |
| run_req | input | 1 | Run request; low halts and holds at start |
| rate_sel | input | 4 | Frame-rate select; 4'b1111 blocks frames |
| frame_tick | input | 1 | One-cycle pulse per incoming audio frame |
| instr_word | input | INSTR_W (24) | Instruction word read at `fetch_addr` |
| fetch_addr | output | ADDR_W (8) | Program memory fetch address |
| instr_valid | output | 1 | High on cycles that fetch a real instruction |
| overrun | output | 1 | Sticky: a frame arrived before the program ended |

## Verification
The main fetch loop is tried with several kinds of program:
- Short programs whose jump sits at different addresses. These show whether the sequencer parks on the right instruction.
- A program with no jump at all. This runs the address through its wrap-around and separates modulo counting from saturation.
- A jump fetched in the same cycle as a frame tick. This shows that frame priority and overrun marking are correct.

Random sequences then mix enable, run, rate codes and frame ticks against a bench model. These expose wrong gating order, such as a blocked rate code still starting the program, or a halt that leaves the strobe high.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int RATE_W = 4;
    localparam logic [RATE_W-1:0] RATE_NONE = 4'b1111;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // qualified controls handed from the gate to the counter
    typedef struct packed {
        logic run_ok;   // enable and run both asserted
        logic start;    // accepted frame this cycle
    } gate_t;

    function automatic logic rate_blocks(input logic [RATE_W-1:0] code);
        return code == RATE_NONE;
    endfunction

endpackage

// File: rtl/seq_frame_gate.sv
module seq_frame_gate
    import seq_pkg::*;
(
    input  logic              core_en,
    input  logic              run_req,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              frame_tick,
    output gate_t             gate
);

    always_comb begin
        gate.run_ok = core_en && run_req;
        gate.start  = gate.run_ok && frame_tick && !rate_blocks(rate_sel);
    end

endmodule

// File: rtl/seq_jump_decode.sv
module seq_jump_decode #(
    parameter int INSTR_W = 24,
    parameter int OPC_W   = 5,
    parameter logic [OPC_W-1:0] JUMP_OPC = '1
) (
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               fetching,
    output logic               is_jump
);

    localparam int OPC_LSB = INSTR_W - OPC_W;

    logic [OPC_W-1:0] opcode;
    logic             unused_operand;

    assign opcode         = instr_word[INSTR_W-1:OPC_LSB];
    assign unused_operand = ^instr_word[OPC_LSB-1:0];
    assign is_jump        = fetching && (opcode == JUMP_OPC);

endmodule

// File: rtl/seq_pc_ctrl.sv
module seq_pc_ctrl
    import seq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int START_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  gate_t             gate,
    input  logic              is_jump,
    output logic [ADDR_W-1:0] pc,
    output logic              fetching,
    output logic              late_frame
);

    localparam logic [ADDR_W-1:0] START = ADDR_W'(START_ADDR);

    seq_state_e state_q;

    assign fetching   = (state_q == SEQ_RUN);
    assign late_frame = gate.start && fetching;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            pc      <= START;
        end else if (!gate.run_ok) begin
            state_q <= SEQ_IDLE;
            pc      <= START;
        end else if (gate.start) begin
            state_q <= SEQ_RUN;
            pc      <= START;
        end else if (fetching) begin
            if (is_jump) begin
                state_q <= SEQ_IDLE;
                pc      <= START;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end

endmodule

// File: rtl/seq_overrun_flag.sv
module seq_overrun_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (hit) flag <= 1'b1;
    end

endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
    import seq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int INSTR_W    = 24,
    parameter int OPC_W      = 5,
    parameter logic [OPC_W-1:0] JUMP_OPC = 5'h1F,
    parameter int START_ADDR = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               core_en,
    input  logic               run_req,
    input  logic [3:0]         rate_sel,
    input  logic               frame_tick,
    input  logic [INSTR_W-1:0] instr_word,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               instr_valid,
    output logic               overrun
);

    gate_t gate;
    logic  is_jump;
    logic  late_frame;

    seq_frame_gate u_gate (
        .core_en    (core_en),
        .run_req    (run_req),
        .rate_sel   (rate_sel),
        .frame_tick (frame_tick),
        .gate       (gate)
    );

    seq_jump_decode #(
        .INSTR_W  (INSTR_W),
        .OPC_W    (OPC_W),
        .JUMP_OPC (JUMP_OPC)
    ) u_dec (
        .instr_word (instr_word),
        .fetching   (instr_valid),
        .is_jump    (is_jump)
    );

    seq_pc_ctrl #(
        .ADDR_W     (ADDR_W),
        .START_ADDR (START_ADDR)
    ) u_pc (
        .clk        (clk),
        .rst        (rst),
        .gate       (gate),
        .is_jump    (is_jump),
        .pc         (fetch_addr),
        .fetching   (instr_valid),
        .late_frame (late_frame)
    );

    seq_overrun_flag u_ovr (
        .clk  (clk),
        .rst  (rst),
        .hit  (late_frame),
        .flag (overrun)
    );

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
    parameter int ADDR_W     = 8,
    parameter int INSTR_W    = 24,
    parameter int OPC_W      = 5,
    parameter logic [OPC_W-1:0] JUMP_OPC = 5'h1F,
    parameter int START_ADDR = 0
) (
    input logic               clk,
    input logic               rst,
    input logic               core_en,
    input logic               run_req,
    input logic [3:0]         rate_sel,
    input logic               frame_tick,
    input logic [INSTR_W-1:0] instr_word,
    input logic [ADDR_W-1:0]  fetch_addr,
    input logic               instr_valid,
    input logic               overrun
);

    localparam logic [ADDR_W-1:0] START = ADDR_W'(START_ADDR);

    logic go, accepted, jump_seen;
    assign go        = core_en && run_req;
    assign accepted  = go && frame_tick && (rate_sel != 4'b1111);
    assign jump_seen = instr_word[INSTR_W-1 -: OPC_W] == JUMP_OPC;

    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && go && !accepted && !jump_seen)
        |=> (instr_valid && fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)));

    // R4
    jump_park_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && go && !accepted && jump_seen)
        |=> (!instr_valid && fetch_addr == START));

    // R5
    idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> fetch_addr == START);

    // R6
    no_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (!instr_valid && rate_sel == 4'b1111) |=> !instr_valid);

    // R8
    halt_chk: assert property (@(posedge clk) disable iff (rst)
        !go |=> (!instr_valid && fetch_addr == START));

    // R9
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && accepted)
        |=> (overrun && instr_valid && fetch_addr == START));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

bind frame_seq_top frame_seq_chk #(
    .ADDR_W     (ADDR_W),
    .INSTR_W    (INSTR_W),
    .OPC_W      (OPC_W),
    .JUMP_OPC   (JUMP_OPC),
    .START_ADDR (START_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .core_en     (core_en),
    .run_req     (run_req),
    .rate_sel    (rate_sel),
    .frame_tick  (frame_tick),
    .instr_word  (instr_word),
    .fetch_addr  (fetch_addr),
    .instr_valid (instr_valid),
    .overrun     (overrun)
);

// File: tb/frame_seq_top_test.sv
module frame_seq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int INSTR_W    = 24;
    localparam int OPC_W      = 5;
    localparam logic [OPC_W-1:0] JUMP = 5'h1F;
    localparam logic [ADDR_W-1:0] START = '0;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               core_en = 1'b0;
    logic               run_req = 1'b0;
    logic [3:0]         rate_sel = 4'b0001;
    logic               frame_tick = 1'b0;
    logic [INSTR_W-1:0] instr_word;
    logic [ADDR_W-1:0]  fetch_addr;
    logic               instr_valid;
    logic               overrun;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // program image controls
    int jump_at = 5;
    bit no_jump = 1'b0;

    // reference model state
    logic [ADDR_W-1:0] e_pc = START;
    logic              e_v  = 1'b0;
    logic              e_ov = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [INSTR_W-1:0] word_at(input logic [ADDR_W-1:0] a);
        if (!no_jump && int'(a) == jump_at)
            return {JUMP, 19'h0};
        return {OPC_W'(int'(a) % 31), 19'(a)};
    endfunction

    assign instr_word = word_at(fetch_addr);

    frame_seq_top uut (
        .clk         (clk),
        .rst         (rst),
        .core_en     (core_en),
        .run_req     (run_req),
        .rate_sel    (rate_sel),
        .frame_tick  (frame_tick),
        .instr_word  (instr_word),
        .fetch_addr  (fetch_addr),
        .instr_valid (instr_valid),
        .overrun     (overrun)
    );

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            finish_up();
        end
    end

    // model update from the requirements, applied at each edge
    task automatic model_step();
        logic acc;
        acc = frame_tick && core_en && run_req && (rate_sel != 4'b1111);
        if (rst) begin
            e_v = 0; e_pc = START; e_ov = 0;              // R1
        end else if (!(core_en && run_req)) begin
            e_v = 0; e_pc = START;                        // R7 R8
        end else if (acc) begin
            if (e_v) e_ov = 1;                            // R9
            e_v = 1; e_pc = START;                        // R2
        end else if (e_v) begin
            if (word_at(e_pc)[INSTR_W-1 -: OPC_W] == JUMP) begin
                e_v = 0; e_pc = START;                    // R4
            end else begin
                e_pc = e_pc + 1'b1;                       // R3
            end
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        checks++;
        if (fetch_addr !== e_pc || instr_valid !== e_v || overrun !== e_ov) begin
            failures++;
            $display("FAIL %s: actual addr=%0d valid=%0b ovr=%0b expected addr=%0d valid=%0b ovr=%0b",
                     tag, fetch_addr, instr_valid, overrun, e_pc, e_v, e_ov);
        end
    endtask

    task automatic frame_pulse(input string tag);
        frame_tick = 1'b1;
        cyc(tag);
        frame_tick = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EC0_0123));
        // R1 reset state
        cyc("R1");
        cyc("R1");
        rst = 1'b0;
        core_en = 1'b1;
        run_req = 1'b1;
        cyc("R5");

        // R2 start, R3 stepping, R4 park on jump at address 5
        jump_at = 5;
        frame_pulse("R2");
        for (int i = 0; i < 6; i++) cyc("R3");
        for (int i = 0; i < 4; i++) cyc("R4");
        cyc("R5");

        // R6 blocked rate code
        rate_sel = 4'b1111;
        frame_pulse("R6");
        for (int i = 0; i < 3; i++) cyc("R6");
        rate_sel = 4'b0001;

        // R7 core disabled
        core_en = 1'b0;
        frame_pulse("R7");
        for (int i = 0; i < 3; i++) cyc("R7");
        core_en = 1'b1;

        // R8 halt in mid-program
        jump_at = 20;
        frame_pulse("R2");
        for (int i = 0; i < 3; i++) cyc("R3");
        run_req = 1'b0;
        cyc("R8");
        cyc("R8");
        run_req = 1'b1;
        cyc("R5");

        // R9 late frame, then R10 sticky
        frame_pulse("R2");
        for (int i = 0; i < 4; i++) cyc("R3");
        frame_pulse("R9");
        for (int i = 0; i < 25; i++) cyc("R10");

        // R9 frame in the same cycle as the jump fetch (jump at 3)
        rst = 1'b1; cyc("R1"); rst = 1'b0;
        jump_at = 3;
        frame_pulse("R2");
        cyc("R3"); cyc("R3"); cyc("R3");
        frame_pulse("R9");
        for (int i = 0; i < 5; i++) cyc("R4");

        // R3 wrap with no jump in the program
        no_jump = 1'b1;
        frame_pulse("R2");
        for (int i = 0; i < 260; i++) cyc("R3");
        run_req = 1'b0; cyc("R8"); run_req = 1'b1;
        no_jump = 1'b0;

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            core_en    = ($urandom_range(0, 15) != 0);
            run_req    = ($urandom_range(0, 15) != 0);
            rate_sel   = ($urandom_range(0, 7) == 0) ? 4'b1111 : 4'($urandom_range(0, 14));
            frame_tick = ($urandom_range(0, 19) == 0);
            if (!e_v && $urandom_range(0, 9) == 0) jump_at = $urandom_range(0, 40);
            rst        = ($urandom_range(0, 499) == 0);
            cyc("R2");
        end
        rst = 1'b0; frame_tick = 1'b0;

        // R10 only reset clears the flag
        rst = 1'b1; cyc("R10"); rst = 1'b0;
        cyc("R1");
        finish_up();
    end

endmodule